// File: doc/BRIEF.md
# Dual-Channel Sigma-Delta Converter Front End

This block holds the digital half of two first-order sigma-delta modulators. Each channel registers a comparator bit, which is the logic level of an external RC summing node, and drives a feedback pin with the inverse of that registered bit. The feedback pulls the node back toward the switching threshold. While the input bit is high, the channel adds a per-clock weight to an accumulator. Both channels share one period timer. At the end of every sample period, each channel takes its accumulator, clears it, and presents a 16-bit unsigned result. One common strobe marks both results.

The weight is derived from the programmed period so that a window of all-high input lands at full scale whatever the period is. This keeps results on a 16-bit scale, but it adds no real resolution. For example, a window of 1814 clocks still carries only about 10.8 bits of information. A configuration pulse loads a new period. A sequential divider then computes the weight, and sampling resumes only once the divider has finished.

Top module: `sdm_dual_frontend`

## Requirements
- R1: On every clock, each channel's feedback output equals the inverse of its comparator input as registered on the previous rising edge.
- R2: After reset, `active` is 0, `smp_valid` is 0 and `smp_data` is all zero.
- R3: A `cfg_load` pulse latches the period P = max(`cfg_period`, 10) and drops `active` on the next cycle. `active` stays low for at least 31 cycles while the weight is computed, then rises and stays high until the next `cfg_load`.
- R4: The weight is W = floor((2^31 - 1) / (P - 4)). W is added to a channel's accumulator for each clock of the window in which that channel's registered input bit is 1.
- R5: A window spans exactly P consecutive active clocks. `smp_valid` is a one-cycle strobe repeating every P cycles, and one strobe serves both channels.
- R6: A result is min(sum >> 15, 0xFFFF), where sum is the accumulated weight over one window. Channel c occupies `smp_data` bits [16c+15 : 16c].
- R7: The accumulator is cleared at every window boundary. Identical input patterns therefore give identical results in successive windows.
- R8: A `cfg_load` during sampling discards the window in progress without a strobe. `smp_valid` is never high while `active` is low.
- R9: `smp_data` changes only in a cycle where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle pulse that loads `cfg_period` and restarts the weight computation |
| cfg_period | input | 16 | Requested sample period in clocks (values below 10 are raised to 10) |
| cmp_in | input | 2 | Comparator bit per channel (summing-node logic level) |
| fb_out | output | 2 | Feedback drive per channel, the inverse of the registered comparator bit |
| active | output | 1 | High while windows are being accumulated |
| smp_valid | output | 1 | One-cycle strobe that marks fresh results on both channels |
| smp_data | output | 32 | Channel 1 result in the upper half, channel 0 in the lower half |

## Verification
On every cycle, the checker confirms four things: the feedback pin is the inverse of the previous comparator bit, the strobe never lasts two cycles, no strobe appears while sampling is halted, and results stay frozen between strobes. The checker also confirms that a configuration pulse halts sampling. The arithmetic cannot be seen on any single cycle, so the bench scenarios carry it. These cover the weight derived from each period, the count of high clocks across a whole window, saturation at full scale, the clamp on short periods, the spacing between strobes, and a reload that throws away a half-finished window.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SCALE_SH   = 15;
  localparam int WEIGHT_W   = 31;
  localparam int ACC_W      = 33;
  localparam int MIN_PERIOD = 10;
  localparam int OVERHEAD   = 4;

  function automatic logic [SAMPLE_W-1:0] scale_sat(input logic [ACC_W-1:0] total);
    logic [ACC_W-SCALE_SH-1:0] shifted;
    shifted = total[ACC_W-1:SCALE_SH];
    if (shifted > {{(ACC_W-SCALE_SH-SAMPLE_W){1'b0}}, {SAMPLE_W{1'b1}}})
      return {SAMPLE_W{1'b1}};
    else
      return shifted[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/sdm_weight_div.sv
module sdm_weight_div #(
  parameter int PW = 16,
  parameter int QW = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] divisor,
  output logic          done,
  output logic [QW-1:0] quotient
);
  localparam int IW = $clog2(QW);

  logic          busy;
  logic [PW-1:0] rem_q;
  logic [PW-1:0] div_q;
  logic [IW-1:0] idx_q;
  logic [PW:0]   trial;
  logic          fits;

  // dividend is all ones, so the next bit brought down is always 1
  assign trial = {rem_q, 1'b1};
  assign fits  = (trial >= {1'b0, div_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rem_q    <= '0;
      div_q    <= '0;
      idx_q    <= '0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        rem_q    <= '0;
        div_q    <= divisor;
        idx_q    <= IW'(QW-1);
        quotient <= '0;
      end else if (busy) begin
        quotient <= {quotient[QW-2:0], fits};
        rem_q    <= fits ? PW'(trial - {1'b0, div_q}) : trial[PW-1:0];
        if (idx_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdm_period_timer.sv
module sdm_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          last
);
  logic [PW-1:0] cnt_q;

  assign last = run && (cnt_q == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdm_sd_channel.sv
module sdm_sd_channel
  import sdm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                last,
  input  logic [WEIGHT_W-1:0] weight,
  input  logic                cmp,
  output logic                fb,
  output logic [SAMPLE_W-1:0] result
);
  logic             bit_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign fb  = ~bit_q;
  assign sum = acc_q + (bit_q ? ACC_W'(weight) : '0);

  always_ff @(posedge clk) bit_q <= cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      result <= '0;
    end else if (!run) begin
      acc_q <= '0;
    end else if (last) begin
      acc_q  <= '0;
      result <= scale_sat(sum);
    end else begin
      acc_q <= sum;
    end
  end
endmodule

// File: rtl/sdm_dual_frontend.sv
module sdm_dual_frontend
  import sdm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_load,
  input  logic [PW-1:0]           cfg_period,
  input  logic [NCH-1:0]          cmp_in,
  output logic [NCH-1:0]          fb_out,
  output logic                    active,
  output logic                    smp_valid,
  output logic [NCH*SAMPLE_W-1:0] smp_data
);
  logic [PW-1:0]       period_q;
  logic [PW-1:0]       period_eff;
  logic [WEIGHT_W-1:0] weight_div;
  logic [WEIGHT_W-1:0] weight_q;
  logic                div_done;
  logic                last_raw;
  logic                last;

  assign period_eff = (cfg_period < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : cfg_period;

  sdm_weight_div #(.PW(PW), .QW(WEIGHT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (cfg_load),
    .divisor  (period_eff - PW'(OVERHEAD)),
    .done     (div_done),
    .quotient (weight_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= PW'(MIN_PERIOD);
      weight_q <= '0;
      active   <= 1'b0;
    end else if (cfg_load) begin
      period_q <= period_eff;
      active   <= 1'b0;
    end else if (div_done) begin
      weight_q <= weight_div;
      active   <= 1'b1;
    end
  end

  sdm_period_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (active),
    .period (period_q),
    .last   (last_raw)
  );

  assign last = last_raw && !cfg_load;

  always_ff @(posedge clk) begin
    if (rst) smp_valid <= 1'b0;
    else     smp_valid <= last;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sdm_sd_channel u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (active && !cfg_load),
      .last   (last),
      .weight (weight_q),
      .cmp    (cmp_in[c]),
      .fb     (fb_out[c]),
      .result (smp_data[c*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/sdm_dual_checker.sv
module sdm_dual_checker #(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_load,
  input logic [NCH-1:0] cmp_in,
  input logic [NCH-1:0] fb_out,
  input logic           active,
  input logic           smp_valid,
  input logic [DW-1:0]  smp_data
);
  AST_FB_INVERSE: assert property (@(posedge clk) disable iff (rst)
    fb_out == ~$past(cmp_in)); // R1

  AST_LOAD_HALTS: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !active); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |-> !smp_valid); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> $stable(smp_data)); // R9
endmodule

bind sdm_dual_frontend sdm_dual_checker #(.NCH(NCH), .DW(NCH*sdm_pkg::SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_load  (cfg_load),
  .cmp_in    (cmp_in),
  .fb_out    (fb_out),
  .active    (active),
  .smp_valid (smp_valid),
  .smp_data  (smp_data)
);

// File: tb/tb_sdm_dual_frontend.sv
module tb_sdm_dual_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_period = '0;
  logic [1:0]  cmp_in = '0;
  logic [1:0]  fb_out;
  logic        active;
  logic        smp_valid;
  logic [31:0] smp_data;

  int checks = 0;
  int fails  = 0;
  int fb_bad = 0;
  int fb_seen = 0;

  typedef struct { int p; logic [15:0] a; logic [15:0] b; string tag; } item_t;
  item_t q[$];

  // node model: level x out of M=4 per channel
  int na = 0, nb = 0, xa = 0, xb = 0;
  localparam int M = 4;

  always #10 clk = ~clk;

  sdm_dual_frontend dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_period(cfg_period),
    .cmp_in(cmp_in), .fb_out(fb_out), .active(active),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_val(input int p, input int k);
    longint w, s;
    w = 64'd2147483647 / longint'(p - 4);
    s = (longint'(k) * w) >>> 15;
    return (s > 65535) ? 16'hFFFF : s[15:0];
  endfunction

  // R1: feedback vs. registered input, checked before the next drive
  always @(negedge clk) begin
    if (!rst) begin
      fb_seen++;
      if (fb_out != ~cmp_in) fb_bad++;
    end
    cmp_in[0] = (na >= 0);
    cmp_in[1] = (nb >= 0);
    na = na + xa - (cmp_in[0] ? M : 0);
    nb = nb + xb - (cmp_in[1] ? M : 0);
  end

  // monitor / scoreboard
  time last_t = 0;
  int  last_p = 0;
  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected strobe", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(smp_data[15:0] == it.a, {it.tag, " ch0"}, smp_data[15:0], it.a);
        check(smp_data[31:16] == it.b, {it.tag, " ch1"}, smp_data[31:16], it.b);
        if (last_p == it.p && last_t != 0)
          check((($time - last_t) / 20) == it.p, "R5 strobe spacing",
                ($time - last_t) / 20, it.p);
        last_t = $time;
        last_p = it.p;
      end
    end
  end

  task automatic configure(input int req_p, input int a_lvl, input int b_lvl);
    @(negedge clk);
    xa = a_lvl; xb = b_lvl;
    cfg_period = 16'(req_p);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    last_p = 0;
  endtask

  task automatic run_windows(input int req_p, input int a_lvl, input int b_lvl,
                             input int n, input string tag);
    int p;
    p = (req_p < 10) ? 10 : req_p;
    configure(req_p, a_lvl, b_lvl);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.p = p; it.tag = tag;
      it.a = expect_val(p, p * a_lvl / M);
      it.b = expect_val(p, p * b_lvl / M);
      q.push_back(it);
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(active == 1'b0, "R2 active after reset", active, 0);
    check(smp_valid == 1'b0, "R2 valid after reset", smp_valid, 0);
    check(smp_data == '0, "R2 data after reset", smp_data, 0);

    // R3: inactive during weight computation
    configure(16, 4, 0);
    repeat (20) @(negedge clk);
    check(active == 1'b0, "R3 halted while dividing", active, 0);
    repeat (20) @(negedge clk);
    check(active == 1'b1, "R3 active after divide", active, 1);

    run_windows(16, 4, 0, 2, "R6 saturate/zero");
    run_windows(16, 1, 3, 3, "R4 R7 quarter levels");
    run_windows(5, 2, 4, 2, "R3 clamp to 10");
    run_windows(64, 2, 1, 2, "R4 period 64");
    run_windows(1816, 3, 2, 1, "R6 long period");

    // R8: reload mid-window, partial window must vanish
    configure(200, 2, 2);
    wait (active);
    repeat (60) @(negedge clk);
    check(smp_valid == 1'b0 && q.size() == 0, "R8 no early strobe", smp_valid, 0);
    run_windows(12, 1, 2, 2, "R8 after reload");
    check(smp_data[15:0] == expect_val(12, 3), "R9 data held after last strobe",
          smp_data[15:0], expect_val(12, 3));

    check(fb_bad == 0 && fb_seen > 0, "R1 feedback inverse", fb_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule